// File: doc/BRIEF.md
# Dual-Phase Lock-In Demodulator with Biquad Low-Pass

This block is the per-channel core of a digital lock-in detector. A sample from one channel arrives together with a sine and a cosine reference value at the lock-in frequency. The sample is multiplied by each reference, which gives an in-phase and a quadrature product. Each product goes through its own fourth-order low-pass filter. That filter is two identical direct-form-II biquad sections in cascade, computed in 2.30 fixed point. The block then squares the two filtered values and adds them. The result is the squared amplitude of the carrier component, and it is stored at the channel's address in a small two-port result memory.

A single multiplier in each branch is shared across the ten filter products of one sample. Filter state is held separately for every channel, so the channels can be interleaved in any order. A one-cycle interrupt pulse follows the write of the highest-numbered channel, which marks a complete set of channel results. The square root and any scaling are done by software reading the memory.

Top module: `lockin_demod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `irq` are low. Every result-memory word reads zero. All filter states are zero.
- R2: The in-phase product is Q(x·sin) and the quadrature product is Q(x·cos), with x = `smp_data` and the references in signed 2.30 format.
- R3: Each product Q(a·b) is formed at 64 bits, shifted right arithmetically by 30, and saturated to the signed 32-bit range. Every addition and subtraction in the filter also saturates to the signed 32-bit range.
- R4: A biquad section with input u and states s1, s2 computes w = (u − Q(a1·s1)) − Q(a2·s2) and then y = (Q(b0·w) + Q(b1·s1)) + Q(b2·s2), in that order. Only after y has been formed do the states update, with s2 taking s1 and s1 taking w.
- R5: The output of the first section feeds the second section, and both sections use the same five coefficients.
- R6: A sample updates only the filter state and the result word of its own channel.
- R7: The stored result is the unsigned 64-bit value I² + Q² of the two filtered values, and it is written at address `smp_ch`.
- R8: A sample is accepted on a clock edge where `smp_valid` is high and `busy` is low. `busy` is then high for exactly 12 cycles, and the result is written on the edge that ends that window.
- R9: A sample presented while `busy` is high is ignored. It changes no state and no result.
- R10: `irq` is high for exactly one cycle, right after the write for channel NCH−1. No other channel raises it.
- R11: `rd_data` returns the memory word at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample present |
| smp_ch | input | CHW | Channel index of the sample |
| smp_data | input | 32 | Signed input sample |
| ref_sin | input | 32 | Sine reference, signed 2.30 |
| ref_cos | input | 32 | Cosine reference, signed 2.30 |
| busy | output | 1 | A sample is being processed |
| rd_addr | input | CHW | Result memory read address |
| rd_data | output | 64 | Result word, I² + Q², unsigned |
| irq | output | 1 | One-cycle pulse after the last channel's write |

## Verification
The assertions check, on every cycle, the following:
- the interrupt is a single pulse, and it comes exactly as `busy` falls;
- the busy window never exceeds its fixed length;
- the two branch filters finish in lockstep;
- the mixer products stay frozen while a sample is in flight, so a sample offered during that time cannot disturb them.

Only the bench scenarios can show that the numbers are right. The bench runs the fixed-point arithmetic with its saturation cases, the two-section recurrence, isolation between channels, memory addressing, and the rule that the interrupt comes only for the last channel. It does this by comparing every stored result against an arithmetic model over sweeps of channels, reference phases and amplitudes.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

    localparam int DW   = 32;
    localparam int FRAC = 30;
    localparam int PW   = 2 * DW;

    typedef logic signed [DW-1:0] smp_t;
    typedef logic [PW-1:0]        pwr_t;

    typedef struct packed {
        smp_t b0;
        smp_t b1;
        smp_t b2;
        smp_t a1;
        smp_t a2;
    } bq_coef_t;

    // Butterworth section, corner near 10 Hz at 16 kSPS, 2.30 format
    localparam bq_coef_t LP_COEF_DEFAULT = '{
        b0: 32'sd4128,
        b1: 32'sd8256,
        b2: 32'sd4128,
        a1: -32'sd2141528676,
        a2: 32'sd1067799737
    };

    typedef enum logic [2:0] {
        OP_FB1 = 3'd0,
        OP_FB2 = 3'd1,
        OP_FF0 = 3'd2,
        OP_FF1 = 3'd3,
        OP_FF2 = 3'd4
    } bq_op_e;

    function automatic logic signed [PW-1:0] sx64(input smp_t v);
        return $signed({{DW{v[DW-1]}}, v});
    endfunction

    function automatic smp_t clamp32(input logic signed [PW-1:0] v);
        if (v > 64'sd2147483647)       return 32'sh7fffffff;
        else if (v < -64'sd2147483648) return 32'sh80000000;
        else                           return v[DW-1:0];
    endfunction

    function automatic smp_t qmul(input smp_t a, input smp_t b);
        logic signed [PW-1:0] p;
        p = sx64(a) * sx64(b);
        return clamp32(p >>> FRAC);
    endfunction

    function automatic smp_t qadd(input smp_t a, input smp_t b);
        return clamp32(sx64(a) + sx64(b));
    endfunction

    function automatic smp_t qsub(input smp_t a, input smp_t b);
        return clamp32(sx64(a) - sx64(b));
    endfunction

endpackage

// File: rtl/lockin_mixer.sv
module lockin_mixer
    import lockin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  smp_t x,
    input  smp_t rsin,
    input  smp_t rcos,
    output smp_t i_out,
    output smp_t q_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            i_out <= '0;
            q_out <= '0;
        end else if (load) begin
            i_out <= qmul(x, rsin);
            q_out <= qmul(x, rcos);
        end
    end

endmodule

// File: rtl/lockin_bq_engine.sv
module lockin_bq_engine
    import lockin_pkg::*;
#(
    parameter int       NCH  = 4,
    parameter int       CHW  = 2,
    parameter int       NSTG = 2,
    parameter bq_coef_t COEF = LP_COEF_DEFAULT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CHW-1:0] ch,
    input  smp_t           x,
    output logic           done,
    output smp_t           y
);

    localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

    smp_t           st1 [NCH][NSTG];
    smp_t           st2 [NCH][NSTG];
    smp_t           acc, xin, wnew;
    smp_t           cf, opd, prod, acc_nx, cur1, cur2;
    logic [SW-1:0]  stg;
    logic [CHW-1:0] chq;
    bq_op_e         op;
    logic           run;

    assign cur1 = st1[chq][stg];
    assign cur2 = st2[chq][stg];

    // one shared multiplier: coefficient and operand are muxed by the step
    always_comb begin
        cf  = COEF.a1;
        opd = cur1;
        unique case (op)
            OP_FB1: begin cf = COEF.a1; opd = cur1; end
            OP_FB2: begin cf = COEF.a2; opd = cur2; end
            OP_FF0: begin cf = COEF.b0; opd = acc;  end
            OP_FF1: begin cf = COEF.b1; opd = cur1; end
            OP_FF2: begin cf = COEF.b2; opd = cur2; end
            default: ;
        endcase
        prod = qmul(cf, opd);
        unique case (op)
            OP_FB1:  acc_nx = qsub(xin, prod);
            OP_FB2:  acc_nx = qsub(acc, prod);
            OP_FF0:  acc_nx = prod;
            default: acc_nx = qadd(acc, prod);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                for (int s = 0; s < NSTG; s++) begin
                    st1[c][s] <= '0;
                    st2[c][s] <= '0;
                end
            end
            acc  <= '0;
            xin  <= '0;
            wnew <= '0;
            y    <= '0;
            stg  <= '0;
            chq  <= '0;
            op   <= OP_FB1;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                xin <= x;
                chq <= ch;
                stg <= '0;
                op  <= OP_FB1;
                run <= 1'b1;
            end else if (run) begin
                acc <= acc_nx;
                unique case (op)
                    OP_FB1: op <= OP_FB2;
                    OP_FB2: begin wnew <= acc_nx; op <= OP_FF0; end
                    OP_FF0: op <= OP_FF1;
                    OP_FF1: op <= OP_FF2;
                    default: begin
                        st2[chq][stg] <= cur1;
                        st1[chq][stg] <= wnew;
                        xin <= acc_nx;
                        op  <= OP_FB1;
                        if (int'(stg) == NSTG - 1) begin
                            run  <= 1'b0;
                            done <= 1'b1;
                            y    <= acc_nx;
                        end else begin
                            stg <= stg + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/lockin_store.sv
module lockin_store
    import lockin_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [CHW-1:0] wr_ch,
    input  smp_t           i_val,
    input  smp_t           q_val,
    input  logic [CHW-1:0] rd_addr,
    output pwr_t           rd_data,
    output logic           irq
);

    pwr_t mem [NCH];
    pwr_t pwr;
    logic signed [PW-1:0] ie, qe;

    always_comb begin
        ie  = sx64(i_val);
        qe  = sx64(q_val);
        pwr = pwr_t'(ie * ie) + pwr_t'(qe * qe);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) mem[c] <= '0;
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            if (wr) mem[wr_ch] <= pwr;
            rd_data <= mem[rd_addr];
            irq     <= wr && (int'(wr_ch) == NCH - 1);
        end
    end

endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
    import lockin_pkg::*;
#(
    parameter int       NCH  = 4,
    parameter bq_coef_t COEF = LP_COEF_DEFAULT,
    localparam int      CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_valid,
    input  logic [CHW-1:0] smp_ch,
    input  logic [31:0]    smp_data,
    input  logic [31:0]    ref_sin,
    input  logic [31:0]    ref_cos,
    output logic           busy,
    input  logic [CHW-1:0] rd_addr,
    output logic [63:0]    rd_data,
    output logic           irq
);

    localparam int NBR  = 2;
    localparam int NSTG = 2;

    smp_t           mix_v  [NBR];
    smp_t           filt_v [NBR];
    logic [NBR-1:0] done_v;
    logic           accept, start_q, busy_q;
    logic [CHW-1:0] ch_q;

    assign accept = smp_valid && !busy_q;
    assign busy   = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            ch_q    <= '0;
        end else begin
            start_q <= accept;
            if (accept) begin
                busy_q <= 1'b1;
                ch_q   <= smp_ch;
            end else if (done_v[0]) begin
                busy_q <= 1'b0;
            end
        end
    end

    lockin_mixer u_mix (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .x     (smp_t'(smp_data)),
        .rsin  (smp_t'(ref_sin)),
        .rcos  (smp_t'(ref_cos)),
        .i_out (mix_v[0]),
        .q_out (mix_v[1])
    );

    for (genvar b = 0; b < NBR; b++) begin : g_br
        lockin_bq_engine #(
            .NCH  (NCH),
            .CHW  (CHW),
            .NSTG (NSTG),
            .COEF (COEF)
        ) u_eng (
            .clk   (clk),
            .rst   (rst),
            .start (start_q),
            .ch    (ch_q),
            .x     (mix_v[b]),
            .done  (done_v[b]),
            .y     (filt_v[b])
        );
    end

    lockin_store #(
        .NCH (NCH),
        .CHW (CHW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (done_v[0]),
        .wr_ch   (ch_q),
        .i_val   (filt_v[0]),
        .q_val   (filt_v[1]),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

endmodule

// File: rtl/lockin_demod_chk.sv
module lockin_demod_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        irq,
    input logic        done_i,
    input logic        done_q,
    input logic [31:0] mix_i,
    input logic [31:0] mix_q
);

    logic [4:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 5'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !irq));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);

    // R8
    irq_at_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(busy)));

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < 5'd12));

    // R4
    branch_lockstep_chk: assert property (@(posedge clk) disable iff (rst)
        done_i == done_q);

    // R9
    mixer_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mix_i) && $stable(mix_q)));

endmodule

bind lockin_demod lockin_demod_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .irq    (irq),
    .done_i (done_v[0]),
    .done_q (done_v[1]),
    .mix_i  (mix_v[0]),
    .mix_q  (mix_v[1])
);

// File: tb/test_lockin_demod.sv
module test_lockin_demod;

    localparam int NCH = 4;
    localparam int CHW = 2;
    localparam int WDOG = 150000;

    localparam int CB0 = 4128;
    localparam int CB1 = 8256;
    localparam int CB2 = 4128;
    localparam int CA1 = -2141528676;
    localparam int CA2 = 1067799737;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           smp_valid = 1'b0;
    logic [CHW-1:0] smp_ch = '0;
    logic [31:0]    smp_data = '0;
    logic [31:0]    ref_sin = '0;
    logic [31:0]    ref_cos = '0;
    logic           busy;
    logic [CHW-1:0] rd_addr = '0;
    logic [63:0]    rd_data;
    logic           irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int          mw1 [NCH][2][2];
    int          mw2 [NCH][2][2];
    logic [63:0] last [NCH];

    always #5 clk = ~clk;

    lockin_demod i_lockin_demod (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_ch    (smp_ch),
        .smp_data  (smp_data),
        .ref_sin   (ref_sin),
        .ref_cos   (ref_cos),
        .busy      (busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog cycles=%0d expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // R3 arithmetic model
    function automatic int clip(longint v);
        if (v > 64'sd2147483647) return 32'sh7fffffff;
        if (v < -64'sd2147483648) return 32'sh80000000;
        return int'(v);
    endfunction

    function automatic int pm(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        return clip(p >>> 30);
    endfunction

    // R4 R5 model: two equal sections for branch br of channel ch
    function automatic int chain(int ch, int br, int u);
        int v, w, y;
        v = u;
        for (int s = 0; s < 2; s++) begin
            w = clip(longint'(v) - longint'(pm(CA1, mw1[ch][br][s])));
            w = clip(longint'(w) - longint'(pm(CA2, mw2[ch][br][s])));
            y = pm(CB0, w);
            y = clip(longint'(y) + longint'(pm(CB1, mw1[ch][br][s])));
            y = clip(longint'(y) + longint'(pm(CB2, mw2[ch][br][s])));
            mw2[ch][br][s] = mw1[ch][br][s];
            mw1[ch][br][s] = w;
            v = y;
        end
        return v;
    endfunction

    function automatic int refv(int k, bit cosine);
        real ph;
        ph = 6.283185307179586 * real'(k) / 8.0;
        return cosine ? int'(1073741823.0 * $cos(ph)) : int'(1073741823.0 * $sin(ph));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            last[c] = '0;
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 2; s++) begin
                    mw1[c][b][s] = 0;
                    mw2[c][b][s] = 0;
                end
        end
        chk("R1 busy", busy, 0);
        chk("R1 irq", irq, 0);
        for (int c = 0; c < NCH; c++) begin
            rd_addr = CHW'(c);
            @(negedge clk);
            chk("R1 memory", rd_data, 64'd0);
        end
    endtask

    task automatic send(int ch, int x, int s, int c, bit inject);
        int n, iv, qv;
        logic [63:0] e;
        while (busy) @(negedge clk);
        smp_valid = 1'b1;
        smp_ch    = CHW'(ch);
        smp_data  = x;
        ref_sin   = s;
        ref_cos   = c;
        @(negedge clk);
        smp_valid = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            if (inject && n == 4) begin
                // R9 offered while busy
                smp_valid = 1'b1;
                smp_ch    = CHW'((ch + 1) % NCH);
                smp_data  = 32'h7fff0000;
            end else begin
                smp_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        // R2: mixing, then the filter chain of each branch
        iv = chain(ch, 0, pm(x, s));
        qv = chain(ch, 1, pm(x, c));
        e = 64'(longint'(iv) * longint'(iv)) + 64'(longint'(qv) * longint'(qv));
        chk("R8 busy length", 64'(n), 64'd12);
        chk("R10 irq", irq, (ch == NCH - 1) ? 1 : 0);
        rd_addr = CHW'(ch);
        @(negedge clk);
        chk("R7 R11 result", rd_data, e);
        chk("R10 single pulse", irq, 0);
        last[ch] = e;
    endtask

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            rd_addr = CHW'(c);
            @(negedge clk);
            chk("R6 other channels kept", rd_data, last[c]);
        end
    endtask

    initial begin
        do_reset();

        // R2: first sample from zero state, plain references
        send(0, 32'sd1 <<< 26, 32'sd1 <<< 30, 0, 1'b0);

        // R4 R5 R6 R7 R10: sweep over channels, phases and amplitudes
        for (int k = 0; k < 24; k++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                send(ch, ((k * 37 + ch * 11) % 64 - 32) * (1 << 22),
                     refv(k, 1'b0), refv(k, 1'b1), 1'b0);
            end
            if (k % 8 == 7) check_all();
        end

        // R6: long run on one channel, then all others unchanged
        for (int k = 0; k < 16; k++)
            send(1, 1 << 20, refv(k, 1'b0), refv(k, 1'b1), 1'b0);
        check_all();

        // R9: injected samples while busy must leave everything untouched
        for (int k = 0; k < 6; k++)
            send(k % NCH, 12345 * (k + 1), refv(k, 1'b0), refv(k, 1'b1), 1'b1);
        check_all();
        for (int ch = 0; ch < NCH; ch++)
            send(ch, -(1 << 24), refv(ch, 1'b1), refv(ch, 1'b0), 1'b0);

        // R1 again, then R3 saturation of the mixer and of the filter sums
        do_reset();
        send(3, 32'sh80000000, 32'sh80000000, 32'sh7fffffff, 1'b0);
        send(2, 32'sh7fffffff, 32'sh7fffffff, 32'sh80000000, 1'b0);
        for (int k = 0; k < 6; k++)
            send(3, 32'sh80000000, 32'sh80000000, 32'sh7fffffff, 1'b0);
        send(0, 0, 0, 0, 1'b0);
        check_all();

        summary();
        $finish;
    end

endmodule